// File: doc/BRIEF.md
# Sticky Windowed Fault Status Register

This block keeps an 8-bit status byte that records supply and thermal-zone faults until software has seen them. Four voltage channels each bring a measured value and a pair of programmable limits as parallel inputs. A window comparator per channel flags the channel when the value is at or below its low limit, or above its high limit. Three zone fault inputs, two remote-diode fault inputs and one summary fault input feed the remaining bits. The conversion logic, the limit storage and any interrupt pin sit outside the block.

Every status bit is sticky. A fault seen on any clock edge sets its bit, and the bit stays set after the condition goes away. A read on the bus returns the byte as it stood before the read. On the next edge the read clears each bit whose fault is absent in the read cycle. A bit whose fault is still present stays set. A new fault that arrives in the read cycle wins over the clear. Bus writes are decoded and then dropped, so they change nothing.

Top module: `winfault_status`

## Requirements
- R1: While reset is asserted, and right after it is released, the status byte and `rd_data` are 00h.
- R2: The bit of voltage channel c (bit c, for c = 0..3) is set when that channel's value is less than or equal to its low limit. The comparison is unsigned 8-bit, so 90h lies above a low limit of 40h.
- R3: A voltage channel's bit is set when its value is strictly greater than its high limit. A value equal to the high limit does not set it.
- R4: Zone bits sit at positions 4, 5 and 6, one per `zone_fault` bit. Bit 4 is also set by `rdiode_fault[0]` and bit 6 by `rdiode_fault[2]`. `rdiode_fault[1]` has no effect.
- R5: Bit 7 is set when `sum_fault` is high. It follows the same sticky and clear-on-read rules as the other bits.
- R6: A bit that has been set stays set on every edge without a read, even after its fault has gone away.
- R7: A read is `bus_req` high with `bus_we` low. On the edge that ends the read cycle, `rd_data` takes the status byte as it stood before that edge. `rd_data` then holds until the next read.
- R8: On the edge after a read, a bit clears only if its fault is absent during the read cycle. A fault present in that cycle keeps or sets the bit.
- R9: Several bits can be set at once, and a single read reports all of them together.
- R10: A write (`bus_req` and `bus_we` both high) changes neither the status byte nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock inside the block |
| volt_meas | input | 32 | Measured values, channel c in bits [8c+7:8c] |
| volt_lo | input | 32 | Low limits, same packing |
| volt_hi | input | 32 | High limits, same packing |
| zone_fault | input | 3 | Zone fault conditions for bits 4..6 |
| rdiode_fault | input | 3 | Remote-diode open/short indications; entries 0 and 2 are used |
| sum_fault | input | 1 | Summary fault condition for bit 7 |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | Access is a write (ignored) when high, a read when low |
| rd_data | output | 8 | Status byte captured by the last read |

## Verification
A fault condition present in clock cycle t sets its bit on the edge that closes t. The bit can only be seen through a read, and `rd_data` changes on the edge that closes the read cycle. So a fault pulse shows up at the earliest one edge after a read strobe issued in the following cycle. The clear of that read lands on the same edge as the capture, so the next read sees its effect. The bench drives stimulus and samples `rd_data` on falling edges. Its behavioural model moves by exactly one register stage per rising edge and is compared with the design on every cycle. The directed reads check the hand-worked byte values at the falling edge right after each read edge.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int DEF_NUM_VCH  = 4;
  localparam int DEF_VAL_W    = 8;
  localparam int DEF_NUM_ZONE = 3;
  localparam logic [DEF_NUM_ZONE-1:0] DEF_DIODE_MASK = 3'b101;

  function automatic int stat_width(input int nvch, input int nzone);
    return nvch + nzone + 1;
  endfunction

  function automatic int zone_pos(input int nvch, input int z);
    return nvch + z;
  endfunction

  function automatic int err_pos(input int nvch, input int nzone);
    return nvch + nzone;
  endfunction
endpackage

// File: rtl/wfs_rst_sync.sv
module wfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wfs_window_cmp.sv
module wfs_window_cmp #(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] value,
  input  logic [VAL_W-1:0] lim_lo,
  input  logic [VAL_W-1:0] lim_hi,
  output logic             outside
);
  logic at_or_below;
  logic above;

  always_comb begin
    at_or_below = (value <= lim_lo);
    above       = (value >  lim_hi);
    outside     = at_or_below | above;
  end
endmodule

// File: rtl/wfs_fault_collect.sv
module wfs_fault_collect #(
  parameter int                  NUM_VCH    = 4,
  parameter int                  VAL_W      = 8,
  parameter int                  NUM_ZONE   = 3,
  parameter logic [NUM_ZONE-1:0] DIODE_MASK = 3'b101,
  localparam int                 STAT_W     = wfs_pkg::stat_width(NUM_VCH, NUM_ZONE),
  localparam int                 BUS_W      = NUM_VCH * VAL_W
) (
  input  logic [BUS_W-1:0]    volt_meas,
  input  logic [BUS_W-1:0]    volt_lo,
  input  logic [BUS_W-1:0]    volt_hi,
  input  logic [NUM_ZONE-1:0] zone_fault,
  input  logic [NUM_ZONE-1:0] rdiode_fault,
  input  logic                sum_fault,
  output logic [STAT_W-1:0]   flt_vec
);
  logic [NUM_VCH-1:0]  volt_out;
  logic [NUM_ZONE-1:0] zone_live;

  for (genvar ch = 0; ch < NUM_VCH; ch++) begin : g_chan
    wfs_window_cmp #(.VAL_W(VAL_W)) u_cmp (
      .value   (volt_meas[ch*VAL_W +: VAL_W]),
      .lim_lo  (volt_lo[ch*VAL_W +: VAL_W]),
      .lim_hi  (volt_hi[ch*VAL_W +: VAL_W]),
      .outside (volt_out[ch])
    );
  end

  for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone
    if (DIODE_MASK[z]) begin : g_with_diode
      assign zone_live[z] = zone_fault[z] | rdiode_fault[z];
    end else begin : g_plain
      assign zone_live[z] = zone_fault[z] | (1'b0 & rdiode_fault[z]);
    end
  end

  always_comb begin
    flt_vec = '0;
    flt_vec[NUM_VCH-1:0] = volt_out;
    for (int z = 0; z < NUM_ZONE; z++) begin
      flt_vec[wfs_pkg::zone_pos(NUM_VCH, z)] = zone_live[z];
    end
    flt_vec[wfs_pkg::err_pos(NUM_VCH, NUM_ZONE)] = sum_fault;
  end
endmodule

// File: rtl/wfs_sticky_bank.sv
module wfs_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_req,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_d;
  logic         stat_en;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (set_vec[b]) begin
        stat_d[b] = 1'b1;
      end else if (clr_req) begin
        stat_d[b] = 1'b0;
      end else begin
        stat_d[b] = stat_q[b];
      end
    end
  end

  always_comb begin
    stat_en = clr_req | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/wfs_read_port.sv
module wfs_read_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_fire,
  input  logic [W-1:0] stat_q,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] rdat_d;

  always_comb begin
    rdat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_fire) begin
      rd_data <= rdat_d;
    end
  end
endmodule

// File: rtl/winfault_status.sv
module winfault_status #(
  parameter int                  NUM_VCH    = wfs_pkg::DEF_NUM_VCH,
  parameter int                  VAL_W      = wfs_pkg::DEF_VAL_W,
  parameter int                  NUM_ZONE   = wfs_pkg::DEF_NUM_ZONE,
  parameter logic [NUM_ZONE-1:0] DIODE_MASK = wfs_pkg::DEF_DIODE_MASK,
  localparam int                 STAT_W     = wfs_pkg::stat_width(NUM_VCH, NUM_ZONE),
  localparam int                 BUS_W      = NUM_VCH * VAL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_W-1:0]    volt_meas,
  input  logic [BUS_W-1:0]    volt_lo,
  input  logic [BUS_W-1:0]    volt_hi,
  input  logic [NUM_ZONE-1:0] zone_fault,
  input  logic [NUM_ZONE-1:0] rdiode_fault,
  input  logic                sum_fault,
  input  logic                bus_req,
  input  logic                bus_we,
  output logic [STAT_W-1:0]   rd_data
);
  logic              rst_sync_n;
  logic              rd_fire;
  logic [STAT_W-1:0] flt_vec;
  logic [STAT_W-1:0] stat_q;

  // A write is decoded by the absence of rd_fire and has no other path.
  always_comb begin
    rd_fire = bus_req & ~bus_we;
  end

  wfs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wfs_fault_collect #(
    .NUM_VCH    (NUM_VCH),
    .VAL_W      (VAL_W),
    .NUM_ZONE   (NUM_ZONE),
    .DIODE_MASK (DIODE_MASK)
  ) u_collect (
    .volt_meas    (volt_meas),
    .volt_lo      (volt_lo),
    .volt_hi      (volt_hi),
    .zone_fault   (zone_fault),
    .rdiode_fault (rdiode_fault),
    .sum_fault    (sum_fault),
    .flt_vec      (flt_vec)
  );

  wfs_sticky_bank #(.W(STAT_W)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (flt_vec),
    .clr_req (rd_fire),
    .stat_q  (stat_q)
  );

  wfs_read_port #(.W(STAT_W)) u_rdport (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_fire (rd_fire),
    .stat_q  (stat_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/wfs_checker.sv
module wfs_checker #(
  parameter int NUM_VCH = 4,
  parameter int VAL_W   = 8,
  parameter int STAT_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_req,
  input logic                     bus_we,
  input logic                     sum_fault,
  input logic [NUM_VCH*VAL_W-1:0] volt_meas,
  input logic [NUM_VCH*VAL_W-1:0] volt_lo,
  input logic [NUM_VCH*VAL_W-1:0] volt_hi,
  input logic                     rd_fire,
  input logic [STAT_W-1:0]        flt_vec,
  input logic [STAT_W-1:0]        stat_q,
  input logic [STAT_W-1:0]        rd_data
);
  logic [VAL_W-1:0] meas0;
  logic [VAL_W-1:0] lo0;
  logic [VAL_W-1:0] hi0;
  assign meas0 = volt_meas[VAL_W-1:0];
  assign lo0   = volt_lo[VAL_W-1:0];
  assign hi0   = volt_hi[VAL_W-1:0];

  a_r2_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (meas0 <= lo0) |=> stat_q[0]);

  a_r3_high_side: assert property (@(posedge clk) disable iff (!rst_n)
    (meas0 > hi0) |=> stat_q[0]);

  a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
    sum_fault |=> stat_q[STAT_W-1]);

  a_r9_all_faults_land: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(flt_vec)) == $past(flt_vec)));

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> (($past(stat_q) & ~stat_q) == '0));

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rd_data == $past(stat_q)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));

  a_r8_clear_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((stat_q & ~$past(flt_vec)) == '0));

  a_r10_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> ($stable(rd_data) && (($past(stat_q) & ~stat_q) == '0)));
endmodule

bind winfault_status wfs_checker #(
  .NUM_VCH (NUM_VCH),
  .VAL_W   (VAL_W),
  .STAT_W  (STAT_W)
) u_wfs_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .sum_fault (sum_fault),
  .volt_meas (volt_meas),
  .volt_lo   (volt_lo),
  .volt_hi   (volt_hi),
  .rd_fire   (rd_fire),
  .flt_vec   (flt_vec),
  .stat_q    (stat_q),
  .rd_data   (rd_data)
);

// File: tb/winfault_status_bench.sv
`timescale 1ns/1ps
module winfault_status_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  meas [4];
  logic [7:0]  lo   [4];
  logic [7:0]  hi   [4];
  logic [31:0] volt_meas, volt_lo, volt_hi;
  logic [2:0]  zone_fault, rdiode_fault;
  logic        sum_fault, bus_req, bus_we;
  logic [7:0]  rd_data;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";
  logic [7:0] m_stat, m_rd;

  assign volt_meas = {meas[3], meas[2], meas[1], meas[0]};
  assign volt_lo   = {lo[3], lo[2], lo[1], lo[0]};
  assign volt_hi   = {hi[3], hi[2], hi[1], hi[0]};

  winfault_status u_winfault_status (
    .clk(clk), .rst_n(rst_n), .volt_meas(volt_meas), .volt_lo(volt_lo),
    .volt_hi(volt_hi), .zone_fault(zone_fault), .rdiode_fault(rdiode_fault),
    .sum_fault(sum_fault), .bus_req(bus_req), .bus_we(bus_we), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // Fault vector straight from the requirement text.
  function automatic logic [7:0] live_faults();
    logic [7:0] f = 8'h00;
    for (int c = 0; c < 4; c++)
      if (int'(meas[c]) <= int'(lo[c]) || int'(meas[c]) > int'(hi[c])) f[c] = 1'b1;
    if (zone_fault[0] || rdiode_fault[0]) f[4] = 1'b1;
    if (zone_fault[1])                    f[5] = 1'b1;
    if (zone_fault[2] || rdiode_fault[2]) f[6] = 1'b1;
    if (sum_fault)                        f[7] = 1'b1;
    return f;
  endfunction

  // Reference model: one register stage per rising edge.
  always @(posedge clk) begin
    logic [7:0] f;
    logic       rd;
    if (!cmp_on) begin
      m_stat = 8'h00;
      m_rd   = 8'h00;
    end else begin
      f  = live_faults();
      rd = bus_req && !bus_we;
      if (rd) m_rd = m_stat;
      for (int b = 0; b < 8; b++) begin
        if (f[b])    m_stat[b] = 1'b1;
        else if (rd) m_stat[b] = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) chk({cur_req, " model"}, rd_data, m_rd);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0;
    @(negedge clk); bus_req = 1'b0;
  endtask

  task automatic do_write();
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse_meas(input int c, input logic [7:0] v);
    @(negedge clk); meas[c] = v;
    @(negedge clk); meas[c] = 8'h80;
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    zone_fault = 3'b000; rdiode_fault = 3'b000; sum_fault = 1'b0;
    for (int c = 0; c < 4; c++) begin meas[c] = 8'h80; lo[c] = 8'h40; hi[c] = 8'hC0; end
    idle(3);
    chk("R1 in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;
    chk("R1 after release", rd_data, 8'h00);
    do_read(); chk("R1 first read", rd_data, 8'h00);

    cur_req = "R2";
    pulse_meas(0, 8'h40); idle(2);
    do_read(); chk("R2 equal to low", rd_data, 8'h01);
    do_read(); chk("R2 cleared after gone", rd_data, 8'h00);
    pulse_meas(2, 8'h41); do_read(); chk("R2 just above low", rd_data, 8'h00);
    pulse_meas(2, 8'h00); do_read(); chk("R2 zero value", rd_data, 8'h04);
    pulse_meas(3, 8'h90); do_read(); chk("R2 unsigned 90h", rd_data, 8'h00);

    cur_req = "R3";
    pulse_meas(1, 8'hC0); do_read(); chk("R3 equal to high", rd_data, 8'h00);
    pulse_meas(1, 8'hC1); do_read(); chk("R3 above high", rd_data, 8'h02);
    pulse_meas(3, 8'hFF); do_read(); chk("R3 FFh", rd_data, 8'h08);
    do_read();

    cur_req = "R4";
    @(negedge clk); zone_fault[1] = 1'b1; @(negedge clk); zone_fault[1] = 1'b0;
    do_read(); chk("R4 zone2", rd_data, 8'h20);
    @(negedge clk); rdiode_fault[0] = 1'b1; @(negedge clk); rdiode_fault[0] = 1'b0;
    do_read(); chk("R4 diode zone1", rd_data, 8'h10);
    @(negedge clk); rdiode_fault[2] = 1'b1; @(negedge clk); rdiode_fault[2] = 1'b0;
    do_read(); chk("R4 diode zone3", rd_data, 8'h40);
    @(negedge clk); rdiode_fault[1] = 1'b1; @(negedge clk); rdiode_fault[1] = 1'b0;
    do_read(); chk("R4 diode1 ignored", rd_data, 8'h00);

    cur_req = "R5";
    @(negedge clk); sum_fault = 1'b1; @(negedge clk); sum_fault = 1'b0;
    do_read(); chk("R5 summary", rd_data, 8'h80);
    do_read(); chk("R5 summary cleared", rd_data, 8'h00);

    cur_req = "R6";
    @(negedge clk); zone_fault[2] = 1'b1; @(negedge clk); zone_fault[2] = 1'b0;
    idle(7);
    do_read(); chk("R6 sticky after idle", rd_data, 8'h40);

    cur_req = "R8";
    @(negedge clk); zone_fault[0] = 1'b1;
    do_read(); chk("R8 persistent read1", rd_data, 8'h10);
    do_read(); chk("R8 persistent read2", rd_data, 8'h10);
    @(negedge clk); zone_fault[0] = 1'b0;
    do_read(); chk("R8 read with fault just gone", rd_data, 8'h10);
    do_read(); chk("R8 now cleared", rd_data, 8'h00);
    @(negedge clk); zone_fault[1] = 1'b1; bus_req = 1'b1; bus_we = 1'b0;
    @(negedge clk); zone_fault[1] = 1'b0; bus_req = 1'b0;
    chk("R8 set during read not yet seen", rd_data, 8'h00);
    do_read(); chk("R8 set wins over clear", rd_data, 8'h20);

    cur_req = "R7";
    idle(3); chk("R7 holds between reads", rd_data, 8'h20);
    do_read(); chk("R7 read after clear", rd_data, 8'h00);

    cur_req = "R9";
    @(negedge clk); meas[0] = 8'h10; sum_fault = 1'b1; zone_fault[1] = 1'b1;
    @(negedge clk); meas[0] = 8'h80; sum_fault = 1'b0; zone_fault[1] = 1'b0;
    do_read(); chk("R9 three bits", rd_data, 8'hA1);
    do_read(); chk("R9 all cleared", rd_data, 8'h00);

    cur_req = "R10";
    pulse_meas(2, 8'h20);
    do_write(); do_write();
    chk("R10 write leaves rd_data", rd_data, 8'h00);
    do_read(); chk("R10 bit survives writes", rd_data, 8'h04);
    do_write();
    chk("R10 write after read", rd_data, 8'h04);
    do_read(); chk("R10 final clear", rd_data, 8'h00);

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog in %s act=running exp=finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule